// File: doc/BRIEF.md
# DRAM-edge event counter bank

This block sits beside a DRAM controller and counts what the controller reports. It has four 32-bit counters.

Counter 0 is the time base. It advances on every enabled clock cycle. When it wraps, it freezes the whole bank and raises an interrupt. Counters 1 to 3 each have a configuration register holding an event code. The code picks one of three sources:

- a single-cycle strobe from the controller's event vector;
- the AXI read requests whose ID passes a shared masked comparison;
- the AXI write requests whose ID passes the same comparison.

These three counters wrap to zero without any side effect.

Software reaches the block through a plain register port. A write takes effect on the clock edge where `reg_we` is high. A read is combinational from `reg_addr`. The event strobes and request strobes are sampled once per cycle. They have no ready signal and cannot be back-pressured; a strobe high for N cycles counts N events.

Register map (word addresses):
- 0: control. Bit 0 is the global enable. Writing 1 to bit 1 clears the freeze. A read returns the enable in bit 0 and the freeze state in bit 1.
- 1: filter. The mask is in bits [31:16] and the ID value is in bits [15:0].
- 2 to 5: event-code registers for counters 0 to 3, code in bits [7:0].
- 6 to 9: counter values 0 to 3.

Unmapped addresses read as zero.

Top module: `perf_evt_bank`

## Requirements
- R1: After reset, all counters, event codes and the filter read 0. The control register reads 0 and `irq` is low.
- R2: While enabled and not frozen, counter 0 (address 6) increases by exactly 1 per clock cycle, whatever its event-code register (address 2) holds.
- R3: Counters 1 to 3 increase by 1 in each enabled, unfrozen cycle where their selected event is high. Codes 0x00 to 0x0F select `ev_strobe[code]`. Any code other than 0x00 to 0x0F, 0x41 and 0x42 counts nothing.
- R4: Code 0x41 counts cycles with `rd_req_valid` high and `(rd_req_id & mask) == (id & mask)`. Code 0x42 does the same with `wr_req_valid` and `wr_req_id`. A mask bit of 1 takes part in the comparison; a mask bit of 0 is ignored. The mask is filter bits [31:16] and the ID is bits [15:0].
- R5: One filter register serves every counter. Two counters set to 0x41 count the same read requests.
- R6: When counter 0 steps from 0xFFFFFFFF to 0, the freeze is set (control bit 1 reads 1) and `irq` goes high. While frozen, no counter changes except by a register write.
- R7: Counters 1 to 3 wrap from 0xFFFFFFFF to 0 and keep counting, with no freeze and no interrupt.
- R8: Writing control with bit 1 set clears the freeze and drops `irq` at that edge. Counting resumes on the following cycle. If counter 0 wraps in the same cycle, the freeze stays set.
- R9: With control bit 0 at 0, no counter changes except by a register write.
- R10: A write to a counter address loads the written value. The load takes priority over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_strobe | input | 16 | Single-cycle event strobes from the controller |
| rd_req_valid | input | 1 | AXI read request accepted this cycle |
| rd_req_id | input | 16 | ID of that read request |
| wr_req_valid | input | 1 | AXI write request accepted this cycle |
| wr_req_id | input | 16 | ID of that write request |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| irq | output | 1 | High while the bank is frozen by a counter 0 wrap |

## Verification
The hardest state to reach from the ports is the freeze. It needs counter 0 to pass 2^32 cycles.

The stimulus loads counter 0 with a value a few counts below its maximum. It checks the exact value a few cycles later, then lets the wrap occur while counter 1 is counting a held strobe. The bench then confirms that counter 1 stays frozen and that the clear write restarts counter 0 from zero with an exact count.

The filter cases come from a vector table. The table covers:
- full, partial and empty masks;
- requests on the wrong channel;
- a matching ID with no valid strobe.

// File: rtl/perf_pkg.sv
package perf_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 4;
  localparam int CODE_W = 8;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [CODE_W-1:0] evcode_t;
  localparam int A_CTRL = 0;
  localparam int A_FILT = 1;
  localparam int A_CFG0 = 2;
  localparam int A_CNT0 = 6;
  localparam evcode_t EVC_RD_ID = 8'h41;
  localparam evcode_t EVC_WR_ID = 8'h42;
endpackage

// File: rtl/perf_id_filter.sv
module perf_id_filter #(
  parameter int ID_W = 16
) (
  input  logic [ID_W-1:0] mask,
  input  logic [ID_W-1:0] match_id,
  input  logic            rd_valid,
  input  logic [ID_W-1:0] rd_id,
  input  logic            wr_valid,
  input  logic [ID_W-1:0] wr_id,
  output logic            rd_hit,
  output logic            wr_hit
);
  logic [ID_W-1:0] ref_bits;

  assign ref_bits = match_id & mask;
  assign rd_hit = rd_valid && ((rd_id & mask) == ref_bits);
  assign wr_hit = wr_valid && ((wr_id & mask) == ref_bits);
endmodule

// File: rtl/perf_evt_sel.sv
module perf_evt_sel
  import perf_pkg::*;
#(
  parameter int NUM_EV = 16
) (
  input  evcode_t           code,
  input  logic [NUM_EV-1:0] ev,
  input  logic              rd_hit,
  input  logic              wr_hit,
  output logic              sel
);
  localparam int EVI_W = (NUM_EV > 1) ? $clog2(NUM_EV) : 1;
  localparam evcode_t EV_LIMIT = evcode_t'(NUM_EV);

  always_comb begin
    sel = 1'b0;
    if (code == EVC_RD_ID) begin
      sel = rd_hit;
    end else if (code == EVC_WR_ID) begin
      sel = wr_hit;
    end else if (code < EV_LIMIT) begin
      sel = ev[code[EVI_W-1:0]];
    end
  end
endmodule

// File: rtl/perf_counter.sv
module perf_counter #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc,
  input  logic         load,
  input  logic [W-1:0] ldata,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] STEP = 1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q <= '0;
    end else if (load) begin
      q <= ldata;
    end else if (inc) begin
      q <= q + STEP;
    end
  end
endmodule

// File: rtl/perf_regs.sv
module perf_regs
  import perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ID_W    = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      we,
  input  addr_t                     addr,
  input  logic [DATA_W-1:0]         wdata,
  input  logic [NUM_CNT*DATA_W-1:0] cnt_flat,
  input  logic                      ovf0,
  output logic                      en,
  output logic                      locked,
  output logic [ID_W-1:0]           filt_mask,
  output logic [ID_W-1:0]           filt_id,
  output evcode_t [NUM_CNT-1:0]     cfg,
  output logic [NUM_CNT-1:0]        cnt_load,
  output logic [DATA_W-1:0]         rdata
);
  localparam int FILT_W = 2 * ID_W;

  logic wr_ctrl;
  logic wr_filt;
  logic [NUM_CNT-1:0] wr_cfg;

  assign wr_ctrl = we && (addr == addr_t'(A_CTRL));
  assign wr_filt = we && (addr == addr_t'(A_FILT));

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_dec
    assign wr_cfg[g]   = we && (addr == addr_t'(A_CFG0 + g));
    assign cnt_load[g] = we && (addr == addr_t'(A_CNT0 + g));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0;
    end else if (wr_ctrl) begin
      en <= wdata[0];
    end
  end

  // a wrap in the same cycle as a clear keeps the freeze set
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      locked <= 1'b0;
    end else if (ovf0) begin
      locked <= 1'b1;
    end else if (wr_ctrl && wdata[1]) begin
      locked <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      filt_mask <= '0;
      filt_id   <= '0;
    end else if (wr_filt) begin
      filt_mask <= wdata[FILT_W-1:ID_W];
      filt_id   <= wdata[ID_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else begin
      for (int k = 0; k < NUM_CNT; k++) begin
        if (wr_cfg[k]) cfg[k] <= wdata[CODE_W-1:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == addr_t'(A_CTRL)) begin
      rdata[1:0] = {locked, en};
    end else if (addr == addr_t'(A_FILT)) begin
      rdata[FILT_W-1:0] = {filt_mask, filt_id};
    end
    for (int k = 0; k < NUM_CNT; k++) begin
      if (addr == addr_t'(A_CFG0 + k)) rdata[CODE_W-1:0] = cfg[k];
      if (addr == addr_t'(A_CNT0 + k)) rdata = cnt_flat[k*DATA_W +: DATA_W];
    end
  end
endmodule

// File: rtl/perf_evt_bank.sv
module perf_evt_bank
  import perf_pkg::*;
#(
  parameter int NUM_CNT = 4,
  parameter int ID_W    = 16,
  parameter int NUM_EV  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] ev_strobe,
  input  logic              rd_req_valid,
  input  logic [ID_W-1:0]   rd_req_id,
  input  logic              wr_req_valid,
  input  logic [ID_W-1:0]   wr_req_id,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              irq
);
  logic                      ctl_en;
  logic                      lock_q;
  logic [ID_W-1:0]           f_mask;
  logic [ID_W-1:0]           f_id;
  evcode_t [NUM_CNT-1:0]     cfg;
  logic [NUM_CNT-1:0]        load;
  logic [NUM_CNT-1:0]        evt;
  logic [NUM_CNT-1:0]        inc;
  logic [NUM_CNT*DATA_W-1:0] cnt_flat;
  logic                      rd_hit;
  logic                      wr_hit;
  logic                      ovf0;

  perf_regs #(.NUM_CNT(NUM_CNT), .ID_W(ID_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .cnt_flat(cnt_flat), .ovf0(ovf0), .en(ctl_en), .locked(lock_q),
    .filt_mask(f_mask), .filt_id(f_id), .cfg(cfg), .cnt_load(load),
    .rdata(reg_rdata)
  );

  perf_id_filter #(.ID_W(ID_W)) u_filt (
    .mask(f_mask), .match_id(f_id),
    .rd_valid(rd_req_valid), .rd_id(rd_req_id),
    .wr_valid(wr_req_valid), .wr_id(wr_req_id),
    .rd_hit(rd_hit), .wr_hit(wr_hit)
  );

  for (genvar g = 0; g < NUM_CNT; g++) begin : g_cnt
    if (g == 0) begin : g_time
      assign evt[g] = 1'b1;
    end else begin : g_sel
      perf_evt_sel #(.NUM_EV(NUM_EV)) u_sel (
        .code(cfg[g]), .ev(ev_strobe), .rd_hit(rd_hit), .wr_hit(wr_hit),
        .sel(evt[g])
      );
    end
    assign inc[g] = ctl_en && !lock_q && evt[g];
    perf_counter #(.W(DATA_W)) u_ctr (
      .clk(clk), .rst_n(rst_n), .inc(inc[g]), .load(load[g]),
      .ldata(reg_wdata), .q(cnt_flat[g*DATA_W +: DATA_W])
    );
  end

  assign ovf0 = inc[0] && !load[0] && (&cnt_flat[DATA_W-1:0]);
  assign irq  = lock_q;
endmodule

// File: rtl/perf_evt_chk.sv
module perf_evt_chk #(
  parameter int NUM_CNT = 4,
  parameter int W       = 32,
  parameter int AW      = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_we,
  input logic [AW-1:0]      reg_addr,
  input logic [W-1:0]       reg_wdata,
  input logic               irq,
  input logic               en,
  input logic               locked,
  input logic [NUM_CNT*W-1:0] cnt_flat
);
  localparam logic [W-1:0]  ONE    = 1;
  localparam logic [AW-1:0] AD_CTL = 0;
  localparam logic [AW-1:0] AD_C0  = 6;

  logic [W-1:0] cnt0;
  logic         ld0;
  assign cnt0 = cnt_flat[W-1:0];
  assign ld0  = reg_we && (reg_addr == AD_C0);

  a_r9_hold_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !reg_we) |=> $stable(cnt_flat));

  a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !reg_we) |=> $stable(cnt_flat));

  a_r2_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !locked && !ld0) |=> (cnt0 == $past(cnt0) + ONE));

  a_r6_set_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !locked && (cnt0 == '1) && !ld0) |=> (irq && locked));

  a_r7_rise_only_cnt0: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(cnt0) == '1));

  a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && (reg_addr == AD_CTL) && reg_wdata[1] && locked) |=> (!irq && !locked));

  a_r10_load: assert property (@(posedge clk) disable iff (!rst_n)
    ld0 |=> (cnt0 == $past(reg_wdata)));
endmodule

bind perf_evt_bank perf_evt_chk #(.NUM_CNT(NUM_CNT), .W(perf_pkg::DATA_W), .AW(perf_pkg::ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .irq(irq), .en(ctl_en), .locked(lock_q),
  .cnt_flat(cnt_flat)
);

// File: tb/sim_perf_evt_bank.sv
module sim_perf_evt_bank;
  localparam int CLK_PERIOD = 10;
  localparam logic [3:0] AC = 0, AF = 1, AG0 = 2, AG1 = 3, AG2 = 4, AG3 = 5;
  localparam logic [3:0] AN0 = 6, AN1 = 7, AN2 = 8, AN3 = 9;

  typedef struct packed {
    logic [7:0]  code;
    logic [31:0] filt;
    logic        rv;
    logic [15:0] rid;
    logic        wv;
    logic [15:0] wid;
    logic [15:0] ev;
    logic [7:0]  cyc;
    logic [31:0] expv;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{8'h03, 32'h0,         1'b0, 16'h0,    1'b0, 16'h0,    16'h0008, 8'd5, 32'd5}, // R3 selected strobe
    '{8'h03, 32'h0,         1'b0, 16'h0,    1'b0, 16'h0,    16'h0004, 8'd5, 32'd0}, // R3 other strobe
    '{8'h0F, 32'h0,         1'b0, 16'h0,    1'b0, 16'h0,    16'h8000, 8'd2, 32'd2}, // R3 top strobe
    '{8'h7F, 32'h0,         1'b1, 16'h0,    1'b1, 16'h0,    16'hFFFF, 8'd4, 32'd0}, // R3 unused code
    '{8'h41, 32'hFFFF_0012, 1'b1, 16'h0012, 1'b0, 16'h0,    16'h0,    8'd4, 32'd4}, // R4 exact match
    '{8'h41, 32'hFFFF_0012, 1'b1, 16'h0013, 1'b0, 16'h0,    16'h0,    8'd4, 32'd0}, // R4 mismatch
    '{8'h41, 32'hFF00_1200, 1'b1, 16'h12AB, 1'b0, 16'h0,    16'h0,    8'd6, 32'd6}, // R4 partial mask
    '{8'h41, 32'h0000_0000, 1'b1, 16'hBEEF, 1'b0, 16'h0,    16'h0,    8'd3, 32'd3}, // R4 empty mask
    '{8'h41, 32'hFFFF_0012, 1'b0, 16'h0,    1'b1, 16'h0012, 16'h0,    8'd4, 32'd0}, // R4 wrong channel
    '{8'h42, 32'hFFFF_0012, 1'b0, 16'h0,    1'b1, 16'h0012, 16'h0,    8'd4, 32'd4}, // R4 write match
    '{8'h42, 32'hFFFF_0012, 1'b1, 16'h0012, 1'b0, 16'h0,    16'h0,    8'd4, 32'd0}, // R4 read ignored
    '{8'h41, 32'hFFFF_0012, 1'b0, 16'h0012, 1'b0, 16'h0,    16'h0,    8'd3, 32'd0}  // R4 no valid
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] ev_strobe = '0;
  logic        rd_req_valid = 1'b0;
  logic [15:0] rd_req_id = '0;
  logic        wr_req_valid = 1'b0;
  logic [15:0] wr_req_id = '0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  perf_evt_bank u0 (
    .clk(clk), .rst_n(rst_n), .ev_strobe(ev_strobe),
    .rd_req_valid(rd_req_valid), .rd_req_id(rd_req_id),
    .wr_req_valid(wr_req_valid), .wr_req_id(wr_req_id),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_run++;
    if (act !== exp_v) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp_v);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, v2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), v);
      chk($sformatf("R1 addr %0d", a), v, 32'h0);
    end
    chk("R1 irq", {31'b0, irq}, 32'h0);

    wr(AC, 32'h1);

    // R2 time base ignores its code
    wr(AG0, 32'h7F);
    rd(AN0, v);
    repeat (10) @(negedge clk);
    rd(AN0, v2);
    chk("R2 cnt0 step", v2 - v, 32'd10);

    // R3/R4 vector table on counter 1
    for (int i = 0; i < NV; i++) begin
      wr(AG1, {24'b0, TBL[i].code});
      wr(AF, TBL[i].filt);
      wr(AN1, 32'h0);
      ev_strobe = TBL[i].ev;
      rd_req_valid = TBL[i].rv; rd_req_id = TBL[i].rid;
      wr_req_valid = TBL[i].wv; wr_req_id = TBL[i].wid;
      repeat (int'(TBL[i].cyc)) @(negedge clk);
      ev_strobe = '0; rd_req_valid = 1'b0; wr_req_valid = 1'b0;
      rd(AN1, v);
      chk($sformatf("R3/R4 vec %0d", i), v, TBL[i].expv);
    end

    // R5 shared filter
    wr(AF, 32'hFFFF_0055);
    wr(AG1, 32'h41); wr(AG2, 32'h41); wr(AG3, 32'h42);
    wr(AN1, 0); wr(AN2, 0); wr(AN3, 0);
    rd_req_valid = 1'b1; rd_req_id = 16'h0055;
    wr_req_valid = 1'b1; wr_req_id = 16'h0055;
    repeat (2) @(negedge clk);
    wr_req_valid = 1'b0;
    @(negedge clk);
    rd_req_valid = 1'b0;
    rd(AN1, v);  chk("R5 cnt1", v, 32'd3);
    rd(AN2, v);  chk("R5 cnt2", v, 32'd3);
    rd(AN3, v);  chk("R5 cnt3", v, 32'd2);

    // R10 load beats increment
    wr(AG1, 32'h0);
    @(negedge clk);
    ev_strobe[0] = 1'b1;
    reg_we = 1'b1; reg_addr = AN1; reg_wdata = 32'h100;
    @(negedge clk);
    reg_we = 1'b0; ev_strobe[0] = 1'b0;
    rd(AN1, v);  chk("R10 load priority", v, 32'h100);

    // R7 silent wrap of counter 1
    wr(AN1, 32'hFFFF_FFFF);
    ev_strobe[0] = 1'b1;
    repeat (2) @(negedge clk);
    ev_strobe[0] = 1'b0;
    rd(AN1, v);  chk("R7 cnt1 wrapped", v, 32'd1);
    chk("R7 irq low", {31'b0, irq}, 32'h0);
    rd(AC, v);   chk("R7 ctrl", v, 32'h1);

    // R9 disable freezes counting
    wr(AC, 32'h0);
    ev_strobe[0] = 1'b1;
    rd(AN0, v);
    repeat (8) @(negedge clk);
    rd(AN0, v2); chk("R9 cnt0 stable", v2, v);
    rd(AN1, v);  chk("R9 cnt1 stable", v, 32'd1);
    ev_strobe[0] = 1'b0;
    wr(AC, 32'h1);

    // R6 counter 0 expiry
    ev_strobe[0] = 1'b1;
    wr(AN0, 32'hFFFF_FFFA);
    repeat (3) @(negedge clk);
    rd(AN0, v);  chk("R6 cnt0 near max", v, 32'hFFFF_FFFD);
    chk("R6 irq before wrap", {31'b0, irq}, 32'h0);
    repeat (10) @(negedge clk);
    chk("R6 irq set", {31'b0, irq}, 32'h1);
    rd(AC, v);   chk("R6 lock bit", v, 32'h3);
    rd(AN0, v);  chk("R6 cnt0 zero", v, 32'h0);
    rd(AN1, v);
    repeat (5) @(negedge clk);
    rd(AN1, v2); chk("R6 cnt1 frozen", v2, v);
    ev_strobe[0] = 1'b0;

    // R8 clear resumes
    wr(AC, 32'h3);
    chk("R8 irq cleared", {31'b0, irq}, 32'h0);
    rd(AN0, v);  chk("R8 cnt0 held at clear", v, 32'h0);
    repeat (4) @(negedge clk);
    rd(AN0, v);  chk("R8 cnt0 resumed", v, 32'd4);
    rd(AC, v);   chk("R8 ctrl", v, 32'h1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule